// File: doc/BRIEF.md
# Image Header Block Locator

This block inspects a programming image that sits in a byte-wide memory and reports where a requested block begins inside it. When `start` is accepted it first streams the whole image through a 16-bit CRC and rejects the image unless the residue is zero. It then follows the header length byte to a table of fixed-size records. It walks that table in order until a record's ID equals the requested one, and returns that record's 32-bit little-endian start offset.

The memory is read through a single port whose data returns one clock after the address is sampled. A host places the image in memory, drives the image length and the wanted ID, and pulses `start`. When `done` rises, exactly one of `found` or `err` is set, and on a hit `offset` holds the start position. The result stays on the outputs until the next accepted start.

Top module: `hdr_locator`

## Requirements
- R1: The CRC is taken over all `img_len` bytes, starting from zero, with the reflected polynomial 0x8408, one byte per step, least significant bit first. If the result is not zero, the run ends with `done`=1, `err`=1 and `found`=0.
- R2: If `img_len` is below 25 when start is accepted, the run ends at once with `err`=1.
- R3: The header length H is the byte at image offset 24. H = 0 or H > `img_len` ends the run with `err`=1.
- R4: The record count N is the byte at offset H-1. The table fills bytes H to H+9N-1, and the run is an error when H+9N > `img_len`. A table that ends exactly at `img_len` is valid.
- R5: Record i starts at byte H+9i. Its byte 0 is the ID, and bytes 1 to 4 hold the offset with the least significant byte first. The first matching record in table order sets `found`=1, `err`=0 and `offset`.
- R6: If no record matches, including when N = 0, the run ends with `err`=1 and `found`=0. `found` and `err` are never set together.
- R7: A `start` pulse while `busy`=1 is ignored. The running search keeps the ID and length it captured.
- R8: After reset, `busy`, `done`, `found`, `err` and `offset` are all zero. `done`, `found`, `err` and `offset` hold their values until the next accepted start, and `busy` and `done` are never both high.
- R9: While `busy`=1, `mem_addr` is always below the captured image length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a search when idle |
| req_id | input | 8 | Block ID to look for |
| img_len | input | AW | Image length in bytes |
| mem_addr | output | AW | Read address (zero when no read is issued) |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| busy | output | 1 | Search in progress |
| done | output | 1 | Result valid, held until the next start |
| found | output | 1 | Matching record located |
| err | output | 1 | Image rejected or no match |
| offset | output | 32 | Start offset of the matched block |

## Verification
The hardest cases to reach are those where the CRC passes but the table bounds are exactly at their limit. These are a table that ends on the last image byte, one that overruns it by a single byte, and a header length larger than the image. A random image is a poor way to produce them. The bench builds each image itself and then writes the two final bytes so that the residue becomes zero. This lets it set any header and table geometry and still get past the CRC stage. It also hits the duplicate-ID and start-while-busy cases by hand, and mixes these directed images with random ones, some of them deliberately corrupted.

// File: rtl/hl_pkg.sv
package hl_pkg;
    localparam int          HDR_LEN_POS = 24;
    localparam int          HDR_MIN_LEN = HDR_LEN_POS + 1;
    localparam int          REC_BYTES   = 9;
    localparam int          OFF_BYTES   = 4;
    localparam logic [15:0] CRC_POLY    = 16'h8408;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CRC,
        S_HLEN,
        S_CNT,
        S_RID,
        S_OFF
    } st_e;
endpackage

// File: rtl/hdr_crc_byte.sv
module hdr_crc_byte
    import hl_pkg::*;
(
    input  logic [15:0] crc_in,
    input  logic [7:0]  data,
    output logic [15:0] crc_out
);
    logic [8:0][15:0] chain;

    assign chain[0] = crc_in ^ {8'h00, data};

    for (genvar b = 0; b < 8; b++) begin : g_bit
        assign chain[b+1] = chain[b][0] ? ((chain[b] >> 1) ^ CRC_POLY)
                                        : (chain[b] >> 1);
    end

    assign crc_out = chain[8];
endmodule

// File: rtl/hdr_bound_chk.sv
module hdr_bound_chk
    import hl_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] len,
    input  logic [7:0]    hlen_new,
    input  logic [7:0]    hlen_cur,
    input  logic [7:0]    nrec_new,
    output logic          hlen_bad,
    output logic          tbl_bad
);
    localparam int SW = ((AW > 12) ? AW : 12) + 1;

    logic [SW-1:0] tbl_end;

    assign tbl_end  = SW'(hlen_cur) + SW'(nrec_new) * SW'(REC_BYTES);
    assign hlen_bad = (hlen_new == 8'd0) || (SW'(hlen_new) > SW'(len));
    assign tbl_bad  = tbl_end > SW'(len);
endmodule

// File: rtl/hdr_locator.sv
module hdr_locator
    import hl_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    req_id,
    input  logic [AW-1:0] img_len,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          found,
    output logic          err,
    output logic [31:0]   offset
);
    localparam int OBW = $clog2(OFF_BYTES);

    typedef struct packed {
        st_e           st;
        logic [AW-1:0] addr;
        logic [AW-1:0] cnt;
        logic          vld;
        logic          pend;
        logic [15:0]   crc;
        logic [AW-1:0] len;
        logic [7:0]    id;
        logic [7:0]    hlen;
        logic [7:0]    nrec;
        logic [7:0]    idx;
        logic [AW-1:0] base;
        logic [OBW-1:0] bcnt;
        logic [31:0]   off;
        logic          busy;
        logic          done;
        logic          found;
        logic          err;
    } regs_t;

    regs_t r_q, r_d;
    logic        rd_en;
    logic [15:0] crc_nx;
    logic        hlen_bad, tbl_bad;

    hdr_crc_byte u_crc (
        .crc_in  (r_q.crc),
        .data    (mem_rdata),
        .crc_out (crc_nx)
    );

    hdr_bound_chk #(.AW(AW)) u_bnd (
        .len      (r_q.len),
        .hlen_new (mem_rdata),
        .hlen_cur (r_q.hlen),
        .nrec_new (mem_rdata),
        .hlen_bad (hlen_bad),
        .tbl_bad  (tbl_bad)
    );

    always_comb begin
        r_d   = r_q;
        rd_en = 1'b0;

        if (r_q.st == S_CRC) begin
            rd_en = (r_q.addr < r_q.len);
        end else if (r_q.st != S_IDLE) begin
            rd_en = !r_q.pend;
        end
        r_d.vld  = rd_en;
        r_d.pend = r_q.pend | rd_en;

        case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.len   = img_len;
                    r_d.id    = req_id;
                    r_d.done  = 1'b0;
                    r_d.found = 1'b0;
                    r_d.err   = 1'b0;
                    r_d.off   = '0;
                    if (img_len < AW'(HDR_MIN_LEN)) begin
                        r_d.done = 1'b1;
                        r_d.err  = 1'b1;
                    end else begin
                        r_d.st   = S_CRC;
                        r_d.busy = 1'b1;
                        r_d.addr = '0;
                        r_d.cnt  = '0;
                        r_d.crc  = '0;
                        r_d.pend = 1'b0;
                    end
                end
            end
            S_CRC: begin
                if (rd_en) r_d.addr = r_q.addr + AW'(1);
                if (r_q.vld) begin
                    r_d.crc = crc_nx;
                    r_d.cnt = r_q.cnt + AW'(1);
                    if (r_q.cnt == r_q.len - AW'(1)) begin
                        if (crc_nx != 16'h0000) begin
                            r_d.st   = S_IDLE;
                            r_d.busy = 1'b0;
                            r_d.done = 1'b1;
                            r_d.err  = 1'b1;
                        end else begin
                            r_d.st   = S_HLEN;
                            r_d.addr = AW'(HDR_LEN_POS);
                            r_d.pend = 1'b0;
                        end
                    end
                end
            end
            S_HLEN: begin
                if (r_q.vld) begin
                    r_d.pend = 1'b0;
                    if (hlen_bad) begin
                        r_d.st   = S_IDLE;
                        r_d.busy = 1'b0;
                        r_d.done = 1'b1;
                        r_d.err  = 1'b1;
                    end else begin
                        r_d.hlen = mem_rdata;
                        r_d.addr = AW'(mem_rdata) - AW'(1);
                        r_d.st   = S_CNT;
                    end
                end
            end
            S_CNT: begin
                if (r_q.vld) begin
                    r_d.pend = 1'b0;
                    if (tbl_bad || mem_rdata == 8'd0) begin
                        r_d.st   = S_IDLE;
                        r_d.busy = 1'b0;
                        r_d.done = 1'b1;
                        r_d.err  = 1'b1;
                    end else begin
                        r_d.nrec = mem_rdata;
                        r_d.idx  = '0;
                        r_d.base = AW'(r_q.hlen);
                        r_d.addr = AW'(r_q.hlen);
                        r_d.st   = S_RID;
                    end
                end
            end
            S_RID: begin
                if (r_q.vld) begin
                    r_d.pend = 1'b0;
                    if (mem_rdata == r_q.id) begin
                        r_d.st   = S_OFF;
                        r_d.addr = r_q.base + AW'(1);
                        r_d.bcnt = '0;
                    end else if (r_q.idx == r_q.nrec - 8'd1) begin
                        r_d.st   = S_IDLE;
                        r_d.busy = 1'b0;
                        r_d.done = 1'b1;
                        r_d.err  = 1'b1;
                    end else begin
                        r_d.idx  = r_q.idx + 8'd1;
                        r_d.base = r_q.base + AW'(REC_BYTES);
                        r_d.addr = r_q.base + AW'(REC_BYTES);
                    end
                end
            end
            S_OFF: begin
                if (r_q.vld) begin
                    r_d.pend = 1'b0;
                    r_d.off  = {mem_rdata, r_q.off[31:8]};
                    r_d.bcnt = r_q.bcnt + OBW'(1);
                    r_d.addr = r_q.addr + AW'(1);
                    if (r_q.bcnt == OBW'(OFF_BYTES - 1)) begin
                        r_d.st    = S_IDLE;
                        r_d.busy  = 1'b0;
                        r_d.done  = 1'b1;
                        r_d.found = 1'b1;
                    end
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mem_addr = rd_en ? r_q.addr : '0;
    assign busy     = r_q.busy;
    assign done     = r_q.done;
    assign found    = r_q.found;
    assign err      = r_q.err;
    assign offset   = r_q.off;

    p_addr_in_range_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mem_addr < r_q.len));

    p_ignore_start_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (r_q.id == $past(r_q.id)) && (r_q.len == $past(r_q.len)));

    p_hold_result_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done && $stable(found) && $stable(err) && $stable(offset));

    p_busy_done_excl_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_found_err_excl_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        !(found && err));

    p_found_needs_done_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        found |-> done);
endmodule

// File: tb/hdr_locator_test.sv
module hdr_locator_test;
    localparam int CLK_NS = 10;
    localparam int AW     = 16;
    localparam int MEMN   = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [7:0]    req_id = '0;
    logic [AW-1:0] img_len = '0;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata = '0;
    logic          busy, done, found, err;
    logic [31:0]   offset;

    logic [7:0] mem [MEMN];
    int n_chk = 0, n_bad = 0, addr_viol = 0;
    int cur_len = 0;

    always #(CLK_NS/2) clk = ~clk;

    always @(posedge clk) mem_rdata <= mem[mem_addr[8:0]];

    always @(negedge clk) if (busy && int'(mem_addr) >= cur_len) addr_viol++;

    hdr_locator #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_id(req_id),
        .img_len(img_len), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .found(found), .err(err), .offset(offset)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] x = c ^ {8'h00, b};
        for (int k = 0; k < 8; k++) x = x[0] ? ((x >> 1) ^ 16'h8408) : (x >> 1);
        return x;
    endfunction

    function automatic logic [15:0] crc_over(input int n);
        logic [15:0] c = 16'h0000;
        for (int k = 0; k < n; k++) c = crc_step(c, mem[k]);
        return c;
    endfunction

    task automatic seal(input int len);
        logic [15:0] c = crc_over(len - 2);
        mem[len-2] = c[7:0];
        mem[len-1] = c[15:8];
    endtask

    task automatic put_rec(input int base, input logic [7:0] id, input logic [31:0] off);
        mem[base] = id;
        for (int k = 0; k < 4; k++) mem[base+1+k] = off[8*k +: 8];
    endtask

    task automatic fill_rand(input int len);
        for (int k = 0; k < len; k++) mem[k] = 8'($urandom);
    endtask

    // Independent reference walk over the bench memory
    task automatic ref_model(input int len, input logic [7:0] id,
                             output bit f, output bit e, output logic [31:0] o);
        int h, n;
        f = 0; e = 1; o = '0;
        if (len < 25) return;
        if (crc_over(len) != 16'h0000) return;
        h = mem[24];
        if (h == 0 || h > len) return;
        n = mem[h-1];
        if (h + 9*n > len) return;
        for (int i = 0; i < n; i++) begin
            if (mem[h+9*i] == id) begin
                for (int k = 0; k < 4; k++) o[8*k +: 8] = mem[h+9*i+1+k];
                f = 1; e = 0;
                return;
            end
        end
    endtask

    task automatic launch(input int len, input logic [7:0] id);
        @(negedge clk);
        img_len = AW'(len);
        req_id  = id;
        cur_len = len;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (!done) check(0, req, "watchdog: done never rose", 32'(done), 32'd1);
    endtask

    task automatic run_cmp(input int len, input logic [7:0] id, input string req);
        bit f, e;
        logic [31:0] o;
        ref_model(len, id, f, e, o);
        launch(len, id);
        wait_done(req);
        check(done == 1'b1, req, "done", 32'(done), 32'd1);
        check(found == f, req, "found", 32'(found), 32'(f));
        check(err == e, req, "err", 32'(err), 32'(e));
        if (f) check(offset == o, req, "offset", offset, o);
    endtask

    // Standard image: H=32, three records, length 32+27+6
    task automatic std_image(output int len);
        len = 32 + 27 + 6;
        fill_rand(len);
        mem[24] = 8'd32;
        mem[31] = 8'd3;
        put_rec(32, 8'h05, 32'hA1B2C3D4);
        put_rec(41, 8'h08, 32'h00C0FFEE);
        put_rec(50, 8'h05, 32'h12345678);
        seal(len);
    endtask

    initial begin
        #(CLK_NS * 190000);
        check(0, "R8", "global watchdog expired", 32'd0, 32'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int len;
        logic [31:0] sv_off;
        logic sv_f, sv_e;
        void'($urandom(32'd20220216));
        for (int k = 0; k < MEMN; k++) mem[k] = '0;

        repeat (3) @(negedge clk);
        // R8: reset state
        check({busy, done, found, err} == 4'b0000, "R8", "reset flags",
              32'({busy, done, found, err}), 32'd0);
        check(offset == 32'd0, "R8", "reset offset", offset, 32'd0);
        rst_n = 1'b1;

        // R5: match, first of duplicates wins
        std_image(len);
        run_cmp(len, 8'h08, "R5");
        check(offset == 32'h00C0FFEE, "R5", "LE offset second rec", offset, 32'h00C0FFEE);
        run_cmp(len, 8'h05, "R5");
        check(offset == 32'hA1B2C3D4, "R5", "first duplicate wins", offset, 32'hA1B2C3D4);

        // R6: no match
        run_cmp(len, 8'h09, "R6");
        check(err && !found, "R6", "miss gives err", 32'({found, err}), 32'b01);

        // R1: corrupted byte breaks the residue
        mem[40] = mem[40] ^ 8'h10;
        run_cmp(len, 8'h08, "R1");
        check(err == 1'b1, "R1", "crc reject", 32'(err), 32'd1);

        // R2: image too short
        run_cmp(24, 8'h05, "R2");
        check(err == 1'b1, "R2", "short image", 32'(err), 32'd1);

        // R3: header length above image length, and zero
        len = 100; fill_rand(len); mem[24] = 8'd200; seal(len);
        run_cmp(len, 8'h05, "R3");
        check(err == 1'b1, "R3", "hlen too big", 32'(err), 32'd1);
        len = 100; fill_rand(len); mem[24] = 8'd0; seal(len);
        run_cmp(len, 8'h05, "R3");
        check(err == 1'b1, "R3", "hlen zero", 32'(err), 32'd1);

        // R6: zero records
        len = 60; fill_rand(len); mem[24] = 8'd30; mem[29] = 8'd0; seal(len);
        run_cmp(len, mem[30], "R6");
        check(err == 1'b1, "R6", "empty table", 32'(err), 32'd1);

        // R4: table ends exactly at image end (valid), then one byte over
        len = 30 + 9*4; fill_rand(len); mem[24] = 8'd30; mem[29] = 8'd4;
        for (int i = 0; i < 4; i++) put_rec(30 + 9*i, 8'(i + 1), 32'h1000_0000 + 32'(i));
        seal(len);
        run_cmp(len, 8'h04, "R4");
        check(found && offset == 32'h1000_0003, "R4", "exact-fit table", offset, 32'h1000_0003);
        len = 30 + 9*4 - 1; fill_rand(len); mem[24] = 8'd30; mem[29] = 8'd4;
        for (int i = 0; i < 3; i++) put_rec(30 + 9*i, 8'(i + 1), 32'h2000_0000);
        seal(len);
        run_cmp(len, 8'h01, "R4");
        check(err == 1'b1, "R4", "table overruns by one", 32'(err), 32'd1);

        // R7: start during a search is ignored
        std_image(len);
        launch(len, 8'h08);
        repeat (4) @(negedge clk);
        img_len = AW'(30); req_id = 8'h05; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R7");
        check(found && offset == 32'h00C0FFEE, "R7", "busy start ignored", offset, 32'h00C0FFEE);

        // R8: results held without start
        sv_off = offset; sv_f = found; sv_e = err;
        req_id = 8'h77; img_len = AW'(3);
        repeat (6) @(negedge clk);
        check(done && found == sv_f && err == sv_e && offset == sv_off, "R8",
              "hold after done", offset, sv_off);
        check(!busy, "R8", "idle after hold", 32'(busy), 32'd0);

        // Random images, some corrupted (R1, R5, R6)
        for (int it = 0; it < 40; it++) begin
            int h, n, ex;
            h = 26 + int'($urandom_range(34));
            n = int'($urandom_range(6));
            ex = int'($urandom_range(10));
            len = h + 9*n + ex + 2;
            fill_rand(len);
            mem[24] = 8'(h);
            mem[h-1] = 8'(n);
            for (int i = 0; i < n; i++) put_rec(h + 9*i, 8'($urandom_range(5)), 32'($urandom));
            seal(len);
            if ($urandom_range(4) == 0) mem[$urandom_range(len - 1)] ^= 8'h01;
            run_cmp(len, 8'($urandom_range(6)), "R5");
        end

        // R9: no out-of-range read while busy
        check(addr_viol == 0, "R9", "address range", 32'(addr_viol), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule